// File: doc/BRIEF.md
# Audio FIFO Refill Burst Engine

This block keeps two audio sample FIFOs topped up. FIFO A is served by DMA channel 1 and FIFO B by DMA channel 2; in every port vector, bit 0 (or the low field) belongs to FIFO A / channel 1 and bit 1 (or the high field) to FIFO B / channel 2. Each FIFO takes its sample clock from either timer 0 or timer 1, as chosen by a per-FIFO select bit. When the chosen timer overflows, the FIFO drops one sample. The engine looks at the FIFO's level after that pop and decides whether a refill is due.

A refill is a fixed burst of four 32-bit words. Each word is read from the channel's source address through a request/response memory port and is then pushed into that channel's FIFO. After every word the source address moves as the channel's address-step field directs. The FIFO is a fixed destination, so no destination address exists to advance. When the burst ends, the engine can raise a one-cycle completion interrupt. Requests that arrive while a burst runs are held until the engine can start them. When both channels wait at once, channel 1 goes first.

Top module: `afr_top`

## Requirements
- R1: `fifo_pop[i]` is high in exactly the cycles where `tmr_ovf[sel]` is high, where sel is `snd_sel_a` for i=0 and `snd_sel_b` for i=1 (0 = timer 0, 1 = timer 1).
- R2: A timer hit starts a refill only when the post-pop level, which is the FIFO level minus one and never below zero, is less than THRESH (16). The channel must also be enabled, and its 2-bit timing field must be 2'b11 (FIFO mode). Any other timing code or a disabled channel produces no memory read and no push.
- R3: A refill performs exactly four word transfers. Each one is a memory read followed by one push to the requesting channel's FIFO, and the pushed data equals the read data. At most one push bit is high per cycle.
- R4: `rd_req_valid` stays high with a stable `rd_addr` until `rd_req_ready` is seen. A push happens only in a cycle where `rsp_valid` is high.
- R5: After each word, the channel's 2-bit step field changes the source address. A value of 2'b00 adds 4, 2'b01 subtracts 4, and 2'b10 or 2'b11 leaves the address unchanged. The current source address is visible on `src_a`/`src_b`.
- R6: When a channel's interrupt enable is set, `irq_done` for that channel pulses for one cycle, in the cycle after the fourth push. No pulse occurs when the enable is clear.
- R7: A refill request for a channel that arrives while a burst is running is kept, and it is served by a further full burst afterwards.
- R8: When both channels have refills waiting, channel 1 (FIFO A) is served first.
- R9: A `src_wr[i]` strobe loads `src_wr_data` into that channel's source address. After reset the source addresses are zero and `rd_req_valid`, `fifo_push` and `irq_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_ovf | input | 2 | Overflow strobes of timer 0 (bit 0) and timer 1 (bit 1) |
| snd_sel_a | input | 1 | Timer select for FIFO A |
| snd_sel_b | input | 1 | Timer select for FIFO B |
| chan_en | input | 2 | Channel enables |
| chan_timing | input | 4 | Start timing per channel, 2'b11 = FIFO mode |
| chan_adj | input | 4 | Source step control per channel |
| chan_irq_en | input | 2 | Completion interrupt enables |
| src_wr | input | 2 | Source address load strobes |
| src_wr_data | input | AW | Source address load value |
| level_a | input | LVL_W | Current fill level of FIFO A |
| level_b | input | LVL_W | Current fill level of FIFO B |
| fifo_pop | output | 2 | Sample pop strobes |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_addr | output | AW | Memory read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DW | Read data |
| fifo_push | output | 2 | FIFO push strobes |
| push_data | output | DW | Word pushed into the FIFO |
| src_a | output | AW | Channel 1 source address |
| src_b | output | AW | Channel 2 source address |
| irq_done | output | 2 | Completion interrupt pulses |

## Verification
A corrupted source address appears on the very next read request. The bench catches it at the next push, because every pushed word must match the memory content of the address the step rule predicts. A wrong beat count or lost pending flag shows up as a push total that is not a multiple of four, or as a missing burst, once the channel falls idle. A misplaced interrupt is seen in the cycle after the last push. Priority or pending errors show in the channel order of the first pushes.

// File: rtl/afr_pkg.sv
package afr_pkg;
   localparam int NCH = 2;
   localparam logic [1:0] TIMING_FIFO = 2'b11;
   localparam logic [1:0] ADJ_INC = 2'b00;
   localparam logic [1:0] ADJ_DEC = 2'b01;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WAIT = 2'd2
   } burst_st_e;
endpackage

// File: rtl/afr_trigger.sv
module afr_trigger #(
   parameter int LVL_W  = 6,
   parameter int THRESH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       tmr_ovf,
   input  logic             tmr_sel,
   input  logic             ch_en,
   input  logic [1:0]       ch_timing,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             grant,
   output logic             fifo_pop,
   output logic             pend
);
   import afr_pkg::*;

   localparam logic [LVL_W:0] TH = (LVL_W+1)'(THRESH);

   if (THRESH < 1 || THRESH > (1 << LVL_W)) begin : g_bad_thresh
      $error("afr_trigger: THRESH outside level range");
   end

   logic [LVL_W-1:0] post_lvl;
   logic             below;
   logic             req_now;

   assign fifo_pop = tmr_ovf[tmr_sel];
   assign post_lvl = (fifo_level == '0) ? '0 : fifo_level - 1'b1;
   assign below    = {1'b0, post_lvl} < TH;
   assign req_now  = fifo_pop & ch_en & (ch_timing == TIMING_FIFO) & below;

   always_ff @(posedge clk) begin
      if (!rst_n)       pend <= 1'b0;
      else if (req_now) pend <= 1'b1;
      else if (grant)   pend <= 1'b0;
   end

   assert_req_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_now |=> pend);
endmodule

// File: rtl/afr_src_reg.sv
module afr_src_reg #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] wr_addr,
   input  logic          step,
   input  logic [1:0]    adj,
   output logic [AW-1:0] addr
);
   import afr_pkg::*;

   if (AW < 3) begin : g_bad_aw
      $error("afr_src_reg: AW too small for word stepping");
   end

   localparam logic [AW-1:0] WORD = AW'(4);

   logic [AW-1:0] stepped;

   always_comb begin
      case (adj)
         ADJ_INC: stepped = addr + WORD;
         ADJ_DEC: stepped = addr - WORD;
         default: stepped = addr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (wr)   addr <= wr_addr;
      else if (step) addr <= stepped;
   end
endmodule

// File: rtl/afr_burst.sv
module afr_burst #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           pend,
   input  logic [1:0]           irq_en,
   input  logic [1:0][AW-1:0]   src,
   input  logic                 rd_req_ready,
   input  logic                 rsp_valid,
   input  logic [DW-1:0]        rsp_data,
   output logic [1:0]           grant,
   output logic                 rd_req_valid,
   output logic [AW-1:0]        rd_addr,
   output logic [1:0]           fifo_push,
   output logic [DW-1:0]        push_data,
   output logic [1:0]           step,
   output logic [1:0]           irq_done
);
   import afr_pkg::*;

   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

   if (BEATS < 2) begin : g_bad_beats
      $error("afr_burst: BEATS must be at least 2");
   end

   burst_st_e         state;
   logic              ch;
   logic [BEAT_W-1:0] beat;
   logic              fire;

   always_comb begin
      grant = 2'b00;
      if (state == ST_IDLE) begin
         if (pend[0])      grant = 2'b01;
         else if (pend[1]) grant = 2'b10;
      end
   end

   assign rd_req_valid = (state == ST_ADDR);
   assign rd_addr      = src[ch];
   assign fire         = (state == ST_WAIT) & rsp_valid;
   assign fifo_push    = fire ? (ch ? 2'b10 : 2'b01) : 2'b00;
   assign step         = fifo_push;
   assign push_data    = rsp_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ch       <= 1'b0;
         beat     <= '0;
         irq_done <= 2'b00;
      end else begin
         irq_done <= 2'b00;
         case (state)
            ST_IDLE: begin
               if (|grant) begin
                  ch    <= grant[1];
                  beat  <= '0;
                  state <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (rd_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid) begin
                  if (beat == LAST) begin
                     state        <= ST_IDLE;
                     irq_done[ch] <= irq_en[ch];
                  end else begin
                     beat  <= beat + 1'b1;
                     state <= ST_ADDR;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_grant_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_prio_a_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      grant[1] |-> !pend[0]);
   assert_push_needs_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|fifo_push) |-> rsp_valid);
endmodule

// File: rtl/afr_top.sv
module afr_top #(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int LVL_W  = 6,
   parameter int THRESH = 16,
   parameter int BEATS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       tmr_ovf,
   input  logic             snd_sel_a,
   input  logic             snd_sel_b,
   input  logic [1:0]       chan_en,
   input  logic [3:0]       chan_timing,
   input  logic [3:0]       chan_adj,
   input  logic [1:0]       chan_irq_en,
   input  logic [1:0]       src_wr,
   input  logic [AW-1:0]    src_wr_data,
   input  logic [LVL_W-1:0] level_a,
   input  logic [LVL_W-1:0] level_b,
   output logic [1:0]       fifo_pop,
   output logic             rd_req_valid,
   input  logic             rd_req_ready,
   output logic [AW-1:0]    rd_addr,
   input  logic             rsp_valid,
   input  logic [DW-1:0]    rsp_data,
   output logic [1:0]       fifo_push,
   output logic [DW-1:0]    push_data,
   output logic [AW-1:0]    src_a,
   output logic [AW-1:0]    src_b,
   output logic [1:0]       irq_done
);
   import afr_pkg::*;

   logic [1:0]             tmr_sel;
   logic [1:0][LVL_W-1:0]  levels;
   logic [1:0]             pend;
   logic [1:0]             grant;
   logic [1:0]             step;
   logic [1:0][AW-1:0]     src_q;

   assign tmr_sel = {snd_sel_b, snd_sel_a};
   assign levels  = {level_b, level_a};
   assign src_a   = src_q[0];
   assign src_b   = src_q[1];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      afr_trigger #(.LVL_W(LVL_W), .THRESH(THRESH)) u_trig (
         .clk        (clk),
         .rst_n      (rst_n),
         .tmr_ovf    (tmr_ovf),
         .tmr_sel    (tmr_sel[i]),
         .ch_en      (chan_en[i]),
         .ch_timing  (chan_timing[2*i +: 2]),
         .fifo_level (levels[i]),
         .grant      (grant[i]),
         .fifo_pop   (fifo_pop[i]),
         .pend       (pend[i])
      );
      afr_src_reg #(.AW(AW)) u_src (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (src_wr[i]),
         .wr_addr (src_wr_data),
         .step    (step[i]),
         .adj     (chan_adj[2*i +: 2]),
         .addr    (src_q[i])
      );
   end

   afr_burst #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_burst (
      .clk          (clk),
      .rst_n        (rst_n),
      .pend         (pend),
      .irq_en       (chan_irq_en),
      .src          (src_q),
      .rd_req_ready (rd_req_ready),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .grant        (grant),
      .rd_req_valid (rd_req_valid),
      .rd_addr      (rd_addr),
      .fifo_push    (fifo_push),
      .push_data    (push_data),
      .step         (step),
      .irq_done     (irq_done)
   );

   assert_push_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_push));
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));
   assert_irq_after_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_done) |-> $past(|fifo_push));
   assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_done));
endmodule

// File: tb/tb_afr_top.sv
module tb_afr_top;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    tmr_ovf = '0;
   logic          snd_sel_a = 1'b0, snd_sel_b = 1'b0;
   logic [1:0]    chan_en = '0;
   logic [3:0]    chan_timing = '0, chan_adj = '0;
   logic [1:0]    chan_irq_en = '0, src_wr = '0;
   logic [AW-1:0] src_wr_data = '0;
   logic [LW-1:0] level_a = '0, level_b = '0;
   logic [1:0]    fifo_pop, fifo_push, irq_done;
   logic          rd_req_valid;
   logic          rd_req_ready = 1'b1;
   logic [AW-1:0] rd_addr, src_a, src_b;
   logic          rsp_valid = 1'b0;
   logic [DW-1:0] rsp_data = '0, push_data;

   afr_top dut (.*);

   always #4 clk = ~clk;

   int nchk = 0, nerr = 0, cyc = 0;
   int pushes[2], irqs[2];
   int last_push_cyc = -10, first_ch = -1;
   logic [AW-1:0] exp_src[2];
   bit stall = 0, mon_on = 0;
   bit mbusy = 0;
   int mdly = 0;
   logic [AW-1:0] maddr;

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return (a * 32'h0000_9E37) ^ 32'h5A5A_1234;
   endfunction

   function automatic logic [AW-1:0] stepf(input logic [AW-1:0] a, input logic [1:0] adj);
      if (adj == 2'b00) return a + 4;
      if (adj == 2'b01) return a - 4;
      return a;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   // memory model, driven just after the active edge
   always @(posedge clk) begin
      #1;
      if (rsp_valid) rsp_valid = 1'b0;
      rd_req_ready = stall ? 1'($urandom % 2) : 1'b1;
      if (mbusy) begin
         if (mdly == 0) begin
            rsp_valid = 1'b1;
            rsp_data  = memf(maddr);
            mbusy     = 0;
         end else mdly--;
      end else if (rd_req_valid && rd_req_ready) begin
         mbusy = 1;
         maddr = rd_addr;
         mdly  = $urandom % 3;
      end
   end

   // push / interrupt monitor
   always @(negedge clk) begin
      if (mon_on) begin
         for (int c = 0; c < 2; c++) begin
            if (fifo_push[c]) begin
               chk(push_data == memf(exp_src[c]), "R3/R5 push data", push_data, memf(exp_src[c]));
               exp_src[c] = stepf(exp_src[c], chan_adj[2*c +: 2]);
               pushes[c]++;
               last_push_cyc = cyc;
               if (first_ch < 0) first_ch = c;
            end
            if (irq_done[c]) begin
               irqs[c]++;
               chk(last_push_cyc == cyc - 1, "R6 irq timing", cyc - last_push_cyc, 1);
            end
         end
      end
   end

   task automatic load_src(input int c, input logic [AW-1:0] v);
      @(negedge clk);
      src_wr[c] = 1'b1;
      src_wr_data = v;
      @(negedge clk);
      src_wr = '0;
      exp_src[c] = v;
   endtask

   task automatic pulse(input logic [1:0] t);
      @(negedge clk);
      tmr_ovf = t;
      #1;
      chk(fifo_pop == {t[snd_sel_b], t[snd_sel_a]}, "R1 pop", fifo_pop, {t[snd_sel_b], t[snd_sel_a]});
      @(negedge clk);
      tmr_ovf = '0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_counts();
      pushes[0] = 0; pushes[1] = 0; irqs[0] = 0; irqs[1] = 0; first_ch = -1;
   endtask

   initial begin : watchdog
      #1_200_000;
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [AW-1:0] base;
      exp_src[0] = '0; exp_src[1] = '0;
      clr_counts();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      chk(src_a == 0 && src_b == 0, "R9 reset src", src_a, 0);
      chk(rd_req_valid == 0 && fifo_push == 0 && irq_done == 0, "R9 reset outputs",
          {rd_req_valid, fifo_push, irq_done}, 0);
      mon_on = 1;

      // R9 load
      load_src(0, 32'h0000_1000);
      load_src(1, 32'h0000_2000);
      chk(src_a == 32'h1000, "R9 load a", src_a, 32'h1000);
      chk(src_b == 32'h2000, "R9 load b", src_b, 32'h2000);

      // R1 select
      snd_sel_a = 0; snd_sel_b = 1;
      pulse(2'b01);
      pulse(2'b10);

      // R2 threshold boundary: level 17 leaves 16 -> no refill
      chan_en = 2'b11; chan_timing = 4'b1111; chan_adj = 4'b0000; chan_irq_en = 2'b01;
      level_a = 17; clr_counts();
      pulse(2'b01); settle(40);
      chk(pushes[0] == 0, "R2 level 17 no refill", pushes[0], 0);
      // level 16 leaves 15 -> refill, +4 step (R5), irq (R6)
      level_a = 16; clr_counts();
      pulse(2'b01); settle(40);
      chk(pushes[0] == 4, "R2/R3 level 16 refill", pushes[0], 4);
      chk(src_a == 32'h1010, "R5 inc step", src_a, 32'h1010);
      chk(irqs[0] == 1, "R6 irq enabled", irqs[0], 1);
      // R2 disabled timing code / channel
      chan_timing = 4'b1110; clr_counts();
      pulse(2'b01); settle(40);
      chk(pushes[0] == 0, "R2 timing not fifo", pushes[0], 0);
      chan_timing = 4'b1111; chan_en = 2'b10; clr_counts();
      pulse(2'b01); settle(40);
      chk(pushes[0] == 0, "R2 channel disabled", pushes[0], 0);
      chk(rd_req_valid == 0, "R2 no read", rd_req_valid, 0);
      chan_en = 2'b11;

      // R5 decrement and hold, R6 no irq when disabled (channel B on timer 1)
      chan_adj = 4'b0100; chan_irq_en = 2'b00; level_b = 3; clr_counts();
      pulse(2'b10); settle(40);
      chk(pushes[1] == 4, "R3 burst b", pushes[1], 4);
      chk(src_b == 32'h2000 - 16, "R5 dec step", src_b, 32'h2000 - 16);
      chk(irqs[1] == 0, "R6 irq disabled", irqs[1], 0);
      chan_adj = 4'b1110; clr_counts();
      pulse(2'b10); settle(40);
      chk(src_b == 32'h2000 - 16, "R5 hold step", src_b, 32'h2000 - 16);
      chk(pushes[1] == 4, "R3 burst hold", pushes[1], 4);

      // R7 request during busy burst
      chan_adj = 4'b0000; level_a = 0; stall = 1; clr_counts();
      pulse(2'b01); settle(2); pulse(2'b01); settle(120);
      chk(pushes[0] == 8, "R7 pending kept", pushes[0], 8);

      // R8 both at once, A first
      snd_sel_a = 0; snd_sel_b = 0; level_a = 1; level_b = 1; clr_counts();
      pulse(2'b01); settle(120);
      chk(first_ch == 0, "R8 priority", first_ch, 0);
      chk(pushes[0] == 4 && pushes[1] == 4, "R8 both served", pushes[0] + pushes[1], 8);

      // constrained random
      void'($urandom(32'd1234));
      for (int it = 0; it < 30; it++) begin
         logic [1:0] t;
         int ep[2], ei[2];
         bit q;
         snd_sel_a = 1'($urandom); snd_sel_b = 1'($urandom);
         chan_en = 2'($urandom | 1);
         for (int c = 0; c < 2; c++)
            chan_timing[2*c +: 2] = ($urandom % 4 != 0) ? 2'b11 : 2'($urandom);
         chan_adj = 4'($urandom); chan_irq_en = 2'($urandom);
         level_a = LW'($urandom % 32); level_b = LW'($urandom % 32);
         stall = 1'($urandom);
         base = {$urandom} & 32'h00FF_FFF0;
         load_src(0, base);
         load_src(1, base + 32'h100);
         t = 2'($urandom % 3 + 1);
         for (int c = 0; c < 2; c++) begin
            logic [LW-1:0] lv;
            lv = (c == 0) ? level_a : level_b;
            q = t[(c == 0) ? snd_sel_a : snd_sel_b] && chan_en[c]
                && chan_timing[2*c +: 2] == 2'b11 && ((lv == 0 ? 0 : lv - 1) < 16);
            ep[c] = q ? 4 : 0;
            ei[c] = (q && chan_irq_en[c]) ? 1 : 0;
         end
         clr_counts();
         pulse(t);
         settle(150);
         chk(pushes[0] == ep[0], "R2/R3 random a", pushes[0], ep[0]);
         chk(pushes[1] == ep[1], "R2/R3 random b", pushes[1], ep[1]);
         chk(irqs[0] == ei[0] && irqs[1] == ei[1], "R6 random irq", {irqs[1], irqs[0]}, {ei[1], ei[0]});
         chk(src_a == exp_src[0], "R5 random src a", src_a, exp_src[0]);
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule